// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block gathers reset requests from an active-low external reset pin, a debug-port reset (separate assert and negate commands), and a watchdog overflow strobe. The watchdog strobe can be set up to request either a power-on reset or a manual reset. The block turns these requests into six domain reset strobes:

- CPU core
- interrupt bank-number bit
- watchdog control register
- clock-frequency control register
- floating-point unit
- general peripherals

When a reset ends, the block marks the start of exception handling with a one-cycle pulse and a reset-kind code.

Each source clears its own subset of the domains. A pin or debug reset counts only if the request is held for a parameterised minimum number of clock cycles, and the pin is first brought through a two-flop synchronizer. A watchdog power-on reset leaves the watchdog control register and the clock-frequency register alone. A watchdog manual reset touches only the CPU core and the bank-number bit. It is held back while the bus is granted away from the CPU. A separate system-reset output combines the synchronized pin with the watchdog strobe, so a board never has to loop the overflow back onto the pin.

Top module: `rst_ctrl`

## Requirements
- R1: Once the synchronized pin request (pin low) has been seen on MIN_LOW consecutive clock edges, all six domain outputs assert. They stay asserted as long as the pin stays low.
- R2: A pin or debug request lasting fewer than MIN_LOW cycles has no effect. No domain output asserts and exc_start_o does not pulse.
- R3: dbg_rst_assert_i sets a debug request and dbg_rst_negate_i clears it; negate wins if both arrive together. A debug request that lasts at least MIN_LOW cycles acts exactly like a qualified pin request.
- R4: When a qualified pin or debug request ends, all domain outputs drop on the same edge. On that edge exc_start_o pulses for one cycle with exc_kind_o = 2'b01 (power-on).
- R5: A watchdog overflow with wdt_manual_i = 0 asserts the CPU, bank-number, FPU and peripheral outputs for HOLD_CYC cycles. The watchdog-control and frequency-control outputs stay low. The release then pulses exc_start_o with kind 2'b01.
- R6: A watchdog overflow with wdt_manual_i = 1 asserts only the CPU and bank-number outputs for HOLD_CYC cycles. The release then pulses exc_start_o with kind 2'b10 (manual).
- R7: While bus_away_i is high, a manual reset is kept pending with no output asserted. It starts on the first edge at which bus_away_i is low.
- R8: Power-on requests win over manual requests. A pin or debug reset overrides any watchdog reset and discards any pending manual reset. A watchdog power-on overflow discards a pending manual reset and restarts the hold. A manual overflow that arrives while any reset is active or pending is ignored. A watchdog overflow that arrives during a pin or debug reset is ignored.
- R9: exc_kind_o reads 2'b00 in every cycle where exc_start_o is low.
- R10: sys_rst_o is a registered OR of the synchronized pin request and wdt_ovf_i.
- R11: While rst_ni is low, all outputs are low. Every output is driven from a register, so it changes only on clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the controller |
| ext_rst_ni | input | 1 | External reset pin, active low, asynchronous |
| dbg_rst_assert_i | input | 1 | Debug-port reset assert command strobe |
| dbg_rst_negate_i | input | 1 | Debug-port reset negate command strobe |
| wdt_ovf_i | input | 1 | Watchdog counter overflow strobe |
| wdt_manual_i | input | 1 | Overflow kind select: 1 manual, 0 power-on |
| bus_away_i | input | 1 | Bus is released by the CPU or held by a DMA burst |
| rst_cpu_o | output | 1 | CPU core reset |
| rst_ibn_o | output | 1 | Interrupt bank-number bit reset |
| rst_wdtctl_o | output | 1 | Watchdog control register reset |
| rst_frq_o | output | 1 | Clock-frequency control register reset |
| rst_fpu_o | output | 1 | Floating-point unit reset |
| rst_periph_o | output | 1 | General peripheral reset |
| exc_start_o | output | 1 | One-cycle exception-start pulse |
| exc_kind_o | output | 2 | Reset kind: 00 none, 01 power-on, 10 manual |
| sys_rst_o | output | 1 | Whole-system reset request |

## Verification
The bench aims at the qualification boundary. A pin pulse of MIN_LOW-1 cycles must be ignored and a pulse of exactly MIN_LOW cycles must be accepted; an off-by-one counter either drops legitimate resets or accepts glitches. It checks that a watchdog power-on reset never touches the watchdog and frequency registers. A wrong mask would erase the configuration that caused the reset. It holds the bus away during a manual overflow and then fires a power-on request. A controller with broken deferral would reset the CPU in the middle of a burst, or would later replay a stale manual exception after the power-on reset.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

  typedef enum logic [1:0] {
    KIND_NONE = 2'b00,
    KIND_POR  = 2'b01,
    KIND_MAN  = 2'b10
  } rst_kind_e;

  localparam int unsigned NUM_DOM    = 6;
  localparam int unsigned DOM_CPU    = 0;
  localparam int unsigned DOM_IBN    = 1;
  localparam int unsigned DOM_WDTCTL = 2;
  localparam int unsigned DOM_FRQ    = 3;
  localparam int unsigned DOM_FPU    = 4;
  localparam int unsigned DOM_PERIPH = 5;

  typedef logic [NUM_DOM-1:0] dom_mask_t;

  function automatic dom_mask_t dom_bit(input int unsigned idx);
    dom_mask_t m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction

  localparam dom_mask_t MASK_FULL = '1;
  localparam dom_mask_t MASK_MAN  = dom_bit(DOM_CPU) | dom_bit(DOM_IBN);
  localparam dom_mask_t MASK_WPOR = MASK_MAN | dom_bit(DOM_FPU) | dom_bit(DOM_PERIPH);

endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= {STAGES{RST_VAL}};
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/rstc_qual.sv
module rstc_qual #(
  parameter int unsigned MIN_LOW = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic hold_o
);
  localparam int unsigned SAT = MIN_LOW - 1;
  localparam int unsigned CW  = (MIN_LOW > 2) ? $clog2(MIN_LOW) : 1;
  localparam logic [CW-1:0] SAT_V = CW'(SAT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!req_i)           cnt_q <= '0;
    else if (cnt_q != SAT_V)   cnt_q <= cnt_q + 1'b1;
  end

  // qualified once the request has been present for MIN_LOW edges including this one
  assign hold_o = req_i && (cnt_q == SAT_V);
endmodule

// File: rtl/rstc_seq.sv
module rstc_seq
  import rstc_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ext_hold_i,
  input  logic      wdt_ovf_i,
  input  logic      wdt_manual_i,
  input  logic      bus_away_i,
  output dom_mask_t dom_o,
  output logic      exc_o,
  output rst_kind_e kind_o
);
  localparam int unsigned CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_EXT, ST_TIMED, ST_WAIT} st_e;

  st_e       st_q, st_d;
  dom_mask_t mask_q, mask_d;
  logic [CW-1:0] cnt_q, cnt_d;
  rst_kind_e kind_q, kind_d;
  logic      exc_q, exc_d;
  rst_kind_e xkind_q, xkind_d;

  always_comb begin
    st_d    = st_q;
    mask_d  = mask_q;
    cnt_d   = cnt_q;
    kind_d  = kind_q;
    exc_d   = 1'b0;
    xkind_d = KIND_NONE;
    if (ext_hold_i) begin
      st_d   = ST_EXT;
      mask_d = MASK_FULL;
      kind_d = KIND_POR;
    end else if (st_q == ST_EXT) begin
      st_d    = ST_IDLE;
      mask_d  = '0;
      kind_d  = KIND_NONE;
      exc_d   = 1'b1;
      xkind_d = KIND_POR;
    end else if (wdt_ovf_i && !wdt_manual_i) begin
      st_d   = ST_TIMED;
      mask_d = MASK_WPOR;
      cnt_d  = HOLD_LAST;
      kind_d = KIND_POR;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (wdt_ovf_i) begin
            kind_d = KIND_MAN;
            if (bus_away_i) begin
              st_d = ST_WAIT;
            end else begin
              st_d   = ST_TIMED;
              mask_d = MASK_MAN;
              cnt_d  = HOLD_LAST;
            end
          end
        end
        ST_WAIT: begin
          if (!bus_away_i) begin
            st_d   = ST_TIMED;
            mask_d = MASK_MAN;
            cnt_d  = HOLD_LAST;
          end
        end
        ST_TIMED: begin
          if (cnt_q == '0) begin
            st_d    = ST_IDLE;
            mask_d  = '0;
            kind_d  = KIND_NONE;
            exc_d   = 1'b1;
            xkind_d = kind_q;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      mask_q  <= '0;
      cnt_q   <= '0;
      kind_q  <= KIND_NONE;
      exc_q   <= 1'b0;
      xkind_q <= KIND_NONE;
    end else begin
      st_q    <= st_d;
      mask_q  <= mask_d;
      cnt_q   <= cnt_d;
      kind_q  <= kind_d;
      exc_q   <= exc_d;
      xkind_q <= xkind_d;
    end
  end

  assign dom_o  = mask_q;
  assign exc_o  = exc_q;
  assign kind_o = xkind_q;
endmodule

// File: rtl/rst_ctrl.sv
module rst_ctrl
  import rstc_pkg::*;
#(
  parameter int unsigned MIN_LOW     = 8,
  parameter int unsigned HOLD_CYC    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ext_rst_ni,
  input  logic       dbg_rst_assert_i,
  input  logic       dbg_rst_negate_i,
  input  logic       wdt_ovf_i,
  input  logic       wdt_manual_i,
  input  logic       bus_away_i,
  output logic       rst_cpu_o,
  output logic       rst_ibn_o,
  output logic       rst_wdtctl_o,
  output logic       rst_frq_o,
  output logic       rst_fpu_o,
  output logic       rst_periph_o,
  output logic       exc_start_o,
  output logic [1:0] exc_kind_o,
  output logic       sys_rst_o
);
  localparam int unsigned NUM_SRC = 2;

  logic pin_n_s;
  logic dbg_lvl_q;
  logic sys_q;
  logic [NUM_SRC-1:0] req_vec, hold_vec;
  dom_mask_t dom;
  rst_kind_e kind;

  rstc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ext_rst_ni),
    .q_o   (pin_n_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               dbg_lvl_q <= 1'b0;
    else if (dbg_rst_negate_i) dbg_lvl_q <= 1'b0;
    else if (dbg_rst_assert_i) dbg_lvl_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sys_q <= 1'b0;
    else         sys_q <= !pin_n_s || wdt_ovf_i;
  end

  assign req_vec = {dbg_lvl_q, !pin_n_s};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_qual
    rstc_qual #(.MIN_LOW(MIN_LOW)) i_qual (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .req_i (req_vec[g]),
      .hold_o(hold_vec[g])
    );
  end

  rstc_seq #(.HOLD_CYC(HOLD_CYC)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ext_hold_i  (|hold_vec),
    .wdt_ovf_i   (wdt_ovf_i),
    .wdt_manual_i(wdt_manual_i),
    .bus_away_i  (bus_away_i),
    .dom_o       (dom),
    .exc_o       (exc_start_o),
    .kind_o      (kind)
  );

  assign rst_cpu_o    = dom[DOM_CPU];
  assign rst_ibn_o    = dom[DOM_IBN];
  assign rst_wdtctl_o = dom[DOM_WDTCTL];
  assign rst_frq_o    = dom[DOM_FRQ];
  assign rst_fpu_o    = dom[DOM_FPU];
  assign rst_periph_o = dom[DOM_PERIPH];
  assign exc_kind_o   = kind;
  assign sys_rst_o    = sys_q;
endmodule

// File: rtl/rst_ctrl_chk.sv
module rst_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_away_i,
  input logic       rst_cpu_o,
  input logic       rst_ibn_o,
  input logic       rst_wdtctl_o,
  input logic       rst_frq_o,
  input logic       rst_fpu_o,
  input logic       rst_periph_o,
  input logic       exc_start_o,
  input logic [1:0] exc_kind_o
);
  assert_full_mask_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_wdtctl_o || rst_frq_o) |-> (rst_cpu_o && rst_ibn_o && rst_fpu_o && rst_periph_o));

  assert_release_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_start_o |-> ($past(rst_cpu_o) && !rst_cpu_o));

  assert_wdt_por_core_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_periph_o || rst_fpu_o) |-> (rst_cpu_o && rst_ibn_o));

  assert_manual_subset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_cpu_o |-> (rst_ibn_o && (rst_fpu_o == rst_periph_o)));

  assert_defer_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rst_cpu_o) && !rst_periph_o) |-> !$past(bus_away_i));

  assert_kind_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_start_o |-> (exc_kind_o == 2'b00));

  assert_kind_legal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_start_o |-> (exc_kind_o == 2'b01 || exc_kind_o == 2'b10));
endmodule

bind rst_ctrl rst_ctrl_chk i_rst_ctrl_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_away_i  (bus_away_i),
  .rst_cpu_o   (rst_cpu_o),
  .rst_ibn_o   (rst_ibn_o),
  .rst_wdtctl_o(rst_wdtctl_o),
  .rst_frq_o   (rst_frq_o),
  .rst_fpu_o   (rst_fpu_o),
  .rst_periph_o(rst_periph_o),
  .exc_start_o (exc_start_o),
  .exc_kind_o  (exc_kind_o)
);

// File: tb/test_rst_ctrl.sv
`timescale 1ns/1ps
module test_rst_ctrl;
  localparam int MIN_LOW  = 8;
  localparam int HOLD_CYC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_n = 1'b1, dbg_a = 1'b0, dbg_ng = 1'b0, ovf = 1'b0, man = 1'b0, away = 1'b0;
  logic rst_cpu, rst_ibn, rst_wdtctl, rst_frq, rst_fpu, rst_periph, exc, sys_rst;
  logic [1:0] kind;

  int errors = 0, checks = 0;
  int c_cpu, c_wdt, c_frq, c_fpu, c_per, c_por, c_man, c_sys, kind_bad;
  bit done = 0;

  always #5 clk = ~clk;

  rst_ctrl #(.MIN_LOW(MIN_LOW), .HOLD_CYC(HOLD_CYC)) i_rst_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ext_rst_ni(ext_n),
    .dbg_rst_assert_i(dbg_a), .dbg_rst_negate_i(dbg_ng),
    .wdt_ovf_i(ovf), .wdt_manual_i(man), .bus_away_i(away),
    .rst_cpu_o(rst_cpu), .rst_ibn_o(rst_ibn), .rst_wdtctl_o(rst_wdtctl),
    .rst_frq_o(rst_frq), .rst_fpu_o(rst_fpu), .rst_periph_o(rst_periph),
    .exc_start_o(exc), .exc_kind_o(kind), .sys_rst_o(sys_rst)
  );

  // reference model built from the requirements
  logic m_s1, m_s2, m_dbg, m_sys, m_exc;
  int   m_cp, m_cd, m_st, m_cnt;
  logic [5:0] m_mask;
  logic [1:0] m_kind, m_xk;

  function automatic int bump(input logic req, input int c);
    if (!req) return 0;
    return (c >= MIN_LOW - 1) ? c : c + 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 1; m_s2 <= 1; m_dbg <= 0; m_sys <= 0; m_cp <= 0; m_cd <= 0;
      m_st <= 0; m_cnt <= 0; m_mask <= 0; m_kind <= 0; m_exc <= 0; m_xk <= 0;
    end else begin
      logic hold;
      hold = (!m_s2 && m_cp >= MIN_LOW - 1) || (m_dbg && m_cd >= MIN_LOW - 1);
      m_s1 <= ext_n; m_s2 <= m_s1;
      m_dbg <= dbg_ng ? 1'b0 : (dbg_a ? 1'b1 : m_dbg);
      m_sys <= !m_s2 || ovf;
      m_cp <= bump(!m_s2, m_cp);
      m_cd <= bump(m_dbg, m_cd);
      m_exc <= 0; m_xk <= 0;
      if (hold) begin
        m_st <= 1; m_mask <= 6'b111111; m_kind <= 1;
      end else if (m_st == 1) begin
        m_st <= 0; m_mask <= 0; m_kind <= 0; m_exc <= 1; m_xk <= 2'b01;
      end else if (ovf && !man) begin
        m_st <= 2; m_mask <= 6'b110011; m_cnt <= HOLD_CYC - 1; m_kind <= 1;
      end else if (m_st == 0 && ovf) begin
        m_kind <= 2;
        if (away) m_st <= 3;
        else begin m_st <= 2; m_mask <= 6'b000011; m_cnt <= HOLD_CYC - 1; end
      end else if (m_st == 3 && !away) begin
        m_st <= 2; m_mask <= 6'b000011; m_cnt <= HOLD_CYC - 1;
      end else if (m_st == 2) begin
        if (m_cnt == 0) begin
          m_st <= 0; m_mask <= 0; m_kind <= 0; m_exc <= 1; m_xk <= m_kind;
        end else m_cnt <= m_cnt - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    c_cpu = 0; c_wdt = 0; c_frq = 0; c_fpu = 0; c_per = 0; c_por = 0; c_man = 0; c_sys = 0;
  endtask

  task automatic step(input string tag);
    logic [10:0] act, exp;
    @(negedge clk);
    act = {sys_rst, kind, exc, rst_periph, rst_fpu, rst_frq, rst_wdtctl, rst_ibn, rst_cpu};
    exp = {m_sys, m_xk, m_exc, m_mask};
    chk(act == exp, {tag, " model"}, int'(act), int'(exp));
    c_cpu += int'(rst_cpu); c_wdt += int'(rst_wdtctl); c_frq += int'(rst_frq);
    c_fpu += int'(rst_fpu); c_per += int'(rst_periph); c_sys += int'(sys_rst);
    if (exc && kind == 2'b01) c_por++;
    if (exc && kind == 2'b10) c_man++;
    if (!exc && kind != 2'b00) kind_bad++;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic pin_pulse(input int len, input string tag);
    ext_n = 1'b0;
    idle(len, tag);
    ext_n = 1'b1;
  endtask

  task automatic wdt_fire(input logic m, input string tag);
    ovf = 1'b1; man = m;
    step(tag);
    ovf = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    kind_bad = 0;
    // R11: outputs low while held in reset
    repeat (3) @(negedge clk);
    chk({rst_cpu, rst_ibn, rst_wdtctl, rst_frq, rst_fpu, rst_periph, exc, kind, sys_rst} == 0,
        "R11 reset state", int'({rst_cpu, exc, kind, sys_rst}), 0);
    rst_n = 1'b1;
    idle(4, "R11");

    // R2: one cycle short of the minimum
    clr(); pin_pulse(MIN_LOW - 1, "R2"); idle(20, "R2");
    chk(c_cpu == 0, "R2 short pin cpu", c_cpu, 0);
    chk(c_por == 0, "R2 short pin exc", c_por, 0);

    // R1 R4: exactly the minimum, then a longer pulse
    clr(); pin_pulse(MIN_LOW, "R1"); idle(20, "R1");
    chk(c_wdt == 1 && c_cpu == 1, "R1 exact pin mask cycles", c_wdt, 1);
    chk(c_por == 1, "R4 exact pin exc", c_por, 1);
    clr(); pin_pulse(MIN_LOW + 5, "R1"); idle(20, "R1");
    chk(c_frq == 6 && c_per == 6, "R1 long pin hold", c_frq, 6);
    chk(c_por == 1 && c_man == 0, "R4 long pin kind", c_por, 1);

    // R3: debug command pair
    clr(); dbg_a = 1'b1; step("R3"); dbg_a = 1'b0;
    idle(MIN_LOW + 2, "R3"); dbg_ng = 1'b1; step("R3"); dbg_ng = 1'b0; idle(20, "R3");
    chk(c_por == 1 && c_wdt > 0, "R3 debug por", c_por, 1);
    clr(); dbg_a = 1'b1; step("R3"); dbg_a = 1'b0;
    idle(MIN_LOW - 3, "R3"); dbg_ng = 1'b1; step("R3"); dbg_ng = 1'b0; idle(20, "R3");
    chk(c_por == 0 && c_cpu == 0, "R3 short debug ignored", c_por, 0);

    // R5 R10: watchdog power-on
    clr(); wdt_fire(1'b0, "R5"); idle(15, "R5");
    chk(c_cpu == HOLD_CYC && c_fpu == HOLD_CYC, "R5 wdt por hold", c_cpu, HOLD_CYC);
    chk(c_wdt == 0 && c_frq == 0, "R5 wdt regs kept", c_wdt + c_frq, 0);
    chk(c_por == 1, "R5 wdt por exc", c_por, 1);
    chk(c_sys == 1, "R10 sys from wdt", c_sys, 1);
    clr(); pin_pulse(3, "R10"); idle(10, "R10");
    chk(c_sys == 3, "R10 sys from pin", c_sys, 3);

    // R6: manual with bus owned
    clr(); wdt_fire(1'b1, "R6"); idle(15, "R6");
    chk(c_cpu == HOLD_CYC && c_fpu == 0 && c_per == 0, "R6 manual mask", c_cpu, HOLD_CYC);
    chk(c_man == 1 && c_por == 0, "R6 manual exc", c_man, 1);

    // R7: deferral while bus away
    clr(); away = 1'b1; wdt_fire(1'b1, "R7"); idle(20, "R7");
    chk(c_cpu == 0 && c_man == 0, "R7 deferred", c_cpu, 0);
    away = 1'b0; idle(15, "R7");
    chk(c_cpu == HOLD_CYC && c_man == 1, "R7 resumed", c_man, 1);

    // R8: power-on discards pending manual
    clr(); away = 1'b1; wdt_fire(1'b1, "R8"); idle(5, "R8");
    wdt_fire(1'b0, "R8"); idle(15, "R8"); away = 1'b0; idle(15, "R8");
    chk(c_man == 0 && c_por == 1, "R8 wdt por drops manual", c_man, 0);
    clr(); away = 1'b1; wdt_fire(1'b1, "R8"); pin_pulse(MIN_LOW + 2, "R8");
    idle(10, "R8"); away = 1'b0; idle(15, "R8");
    chk(c_man == 0 && c_por == 1, "R8 pin drops manual", c_man, 0);
    clr(); ext_n = 1'b0; idle(MIN_LOW + 4, "R8"); wdt_fire(1'b0, "R8"); wdt_fire(1'b1, "R8");
    idle(3, "R8"); ext_n = 1'b1; idle(20, "R8");
    chk(c_por == 1 && c_man == 0, "R8 wdt ignored under pin", c_por, 1);

    // random mix
    begin
      int pin_run = 0;
      for (int i = 0; i < 6000; i++) begin
        step("RAND");
        dbg_a = ($urandom % 120) == 0;
        dbg_ng = ($urandom % 25) == 0;
        ovf = ($urandom % 40) == 0;
        man = $urandom % 2;
        if (($urandom % 20) == 0) away = ~away;
        if (pin_run == 0) begin
          ext_n = ~ext_n;
          pin_run = ext_n ? int'($urandom_range(5, 60)) : int'($urandom_range(1, 2 * MIN_LOW));
        end else pin_run--;
      end
      ext_n = 1'b1; dbg_a = 0; dbg_ng = 1'b1; ovf = 0; away = 0;
      idle(30, "RAND");
    end

    chk(kind_bad == 0, "R9 kind quiet", kind_bad, 0);
    done = 1;
    summary();
    $finish;
  end
endmodule